// File: doc/BRIEF.md
# JTAG Debug Bridge to APB Master

This block sits behind a JTAG test access port and turns data-register scans into single APB master transfers. The TAP hands it the current 5-bit instruction, the data register contents and an action code. The block answers with a combinational data-out word and a one-hot mark of the topmost valid bit of the register the instruction selects. Four registers are selected by the instruction: a fixed identification word, a control word that reports and clears the sticky error status, a 50-bit access word that carries address, data and operation, and a 1-bit bypass register for every other code.

A debugger scans an access word with operation 1 (read) or 2 (write) and issues update. The transfer then runs on the APB side without further JTAG involvement. A later capture of the access word returns the address last used, the last read data and the status. A capture of the control word shows whether a transfer is still running, so the debugger can poll for completion. A request that arrives while a transfer is still running is dropped and flagged. A slave error also leaves a mark that stays until it is cleared through the control word.

Top module: `jtag_apb_bridge`

## Requirements
- R1: With instruction 1, capture drives the 32-bit identification constant (bit 0 is 1) onto `dr_out`, and `dr_msb_mask` has only bit 31 set.
- R2: Any instruction other than 1, 0x10 and 0x11 selects bypass. Capture drives all zeros, and `dr_msb_mask` has only bit 0 set.
- R3: With instruction 0x10, capture returns the status in bits [11:10] and the busy flag in bit 12, with all other bits zero. `dr_msb_mask` has only bit 31 set.
- R4: With instruction 0x11, capture returns the last transfer address in [49:34], the last read data in [33:2] and the status in [1:0]. `dr_msb_mask` has only bit 49 set.
- R5: Action codes are 0 idle, 1 capture, 2 shift and 3 update. Shift drives `dr_out` to `dr_in` shifted right by one. Idle and update drive `dr_out` equal to `dr_in`.
- R6: An update of the access word with op [1:0]=1 while idle starts a read. The first cycle after the update edge shows psel=1, penable=0, pwrite=0 and paddr=[49:34]. The next cycle shows penable=1.
- R7: Op 2 starts a write in the same way, with pwrite=1 and pwdata=[33:2].
- R8: Op 0 or 3 on an access update, and any update of bypass or identification, starts no transfer.
- R9: The access phase holds psel, penable and paddr until pready is sampled high. A read latches prdata at that edge. Busy is low from the next cycle.
- R10: An access request (op 1 or 2) while busy is dropped and sets the status to 2'b11. This includes a request in the completing cycle.
- R11: pslverr sampled at completion sets the status to 2'b01 if the status was 2'b00. A status of 2'b11 stays 2'b11.
- R12: An update of the control word with any nonzero bit in [17:2] clears the status to 2'b00. This clear wins over a slave error completing at the same edge. With bits [17:2] all zero, the update has no effect.
- R13: After reset, psel and penable are low, and the status, busy flag, last address and read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir | input | 5 | Current instruction from the TAP |
| act | input | 2 | TAP action: 0 idle, 1 capture, 2 shift, 3 update |
| dr_in | input | 50 | Data register contents from the TAP |
| dr_out | output | 50 | Combinational data register result |
| dr_msb_mask | output | 50 | One-hot topmost valid bit of the selected register |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB write direction |
| paddr | output | 16 | APB address |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB slave error |

## Verification
Two pairs of events can fall on one edge. The first pair is the completion of a transfer and a new access update. The bench raises pready in the same cycle that it issues the update and expects the request to be dropped with status 2'b11, while the finished read still lands its data. The second pair is a slave error at completion and a clearing control update. Here the bench expects status 2'b00 on the following capture. Randomized address, data, op, wait-state and error sequences run between these directed cases, and each is judged against a bench-side model of the status, the last address and the read data.

// File: rtl/jab_pkg.sv
// Shared types and constants for the JTAG-to-APB bridge.
// Assumes the TAP encodes its action on two bits as listed below.
package jab_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_SHIFT   = 2'd2,
        ACT_UPDATE  = 2'd3
    } jab_act_e;

    typedef enum logic [1:0] {
        SEL_BYPASS = 2'd0,
        SEL_IDCODE = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_ACCESS = 2'd3
    } jab_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } jab_apb_st_e;

    localparam logic [1:0] OP_READ      = 2'd1;
    localparam logic [1:0] OP_WRITE     = 2'd2;
    localparam logic [1:0] STAT_OK      = 2'b00;
    localparam logic [1:0] STAT_SLVERR  = 2'b01;
    localparam logic [1:0] STAT_OVERLAP = 2'b11;

    // control word field positions
    localparam int CTRL_STAT_LO = 10;
    localparam int CTRL_BUSY    = 12;
    localparam int CTRL_CLR_LO  = 2;
    localparam int CTRL_CLR_HI  = 17;
endpackage

// File: rtl/jab_ir_decode.sv
// Instruction decoder: maps the TAP instruction onto one of four
// register selections. Assumes the instruction codes are distinct.
module jab_ir_decode #(
    parameter int IR_W      = 5,
    parameter int IR_IDCODE = 1,
    parameter int IR_CTRL   = 16,
    parameter int IR_ACCESS = 17
) (
    input  logic [IR_W-1:0]   ir,
    output jab_pkg::jab_sel_e sel
);
    import jab_pkg::*;

    // pick the register addressed by the instruction, bypass otherwise
    always_comb begin
        if (ir == IR_W'(IR_IDCODE))      sel = SEL_IDCODE;
        else if (ir == IR_W'(IR_CTRL))   sel = SEL_CTRL;
        else if (ir == IR_W'(IR_ACCESS)) sel = SEL_ACCESS;
        else                             sel = SEL_BYPASS;
    end
endmodule

// File: rtl/jab_scan_mux.sv
// Scan data path: builds the capture values, the shift result and the
// topmost-valid-bit mask. Purely combinational; the TAP samples dr_out.
module jab_scan_mux #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 32,
    parameter int          ID_W     = 32,
    parameter int          CTRL_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h0A35_C0DF,
    localparam int         DR_W     = ADDR_W + DATA_W + 2
) (
    input  jab_pkg::jab_act_e act,
    input  jab_pkg::jab_sel_e sel,
    input  logic [DR_W-1:0]   dr_in,
    input  logic [1:0]        status,
    input  logic              busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] rdata,
    output logic [DR_W-1:0]   dr_out,
    output logic [DR_W-1:0]   dr_msb_mask
);
    import jab_pkg::*;

    logic [DR_W-1:0] cap_val;
    logic [DR_W-1:0] ctrl_val;

    // control word: status and busy flag, zero elsewhere
    always_comb begin
        ctrl_val = '0;
        ctrl_val[CTRL_STAT_LO +: 2] = status;
        ctrl_val[CTRL_BUSY]         = busy;
    end

    // capture value of the selected register
    always_comb begin
        case (sel)
            SEL_IDCODE: cap_val = DR_W'(ID_VALUE);
            SEL_CTRL:   cap_val = ctrl_val;
            SEL_ACCESS: cap_val = {last_addr, rdata, status};
            default:    cap_val = '0;
        endcase
    end

    // output word according to the TAP action
    always_comb begin
        case (act)
            ACT_CAPTURE: dr_out = cap_val;
            ACT_SHIFT:   dr_out = dr_in >> 1;
            default:     dr_out = dr_in;
        endcase
    end

    // topmost valid bit of the selected register
    always_comb begin
        dr_msb_mask = '0;
        case (sel)
            SEL_IDCODE: dr_msb_mask[ID_W-1]   = 1'b1;
            SEL_CTRL:   dr_msb_mask[CTRL_W-1] = 1'b1;
            SEL_ACCESS: dr_msb_mask[DR_W-1]   = 1'b1;
            default:    dr_msb_mask[0]        = 1'b1;
        endcase
    end

    // mask must always mark exactly one bit
    always_comb begin
        AST_MASK_ONEHOT: assert ($onehot(dr_msb_mask)); // R1
    end
endmodule

// File: rtl/jab_apb_master.sv
// Single-transfer APB master: setup phase, then access phase held until
// pready. Latches read data at completion. Assumes start only when idle.
module jab_apb_master #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    input  logic              pslverr,
    output logic              busy,
    output logic              err_done,
    output logic [DATA_W-1:0] rdata
);
    import jab_pkg::*;

    jab_apb_st_e state;
    logic        done;

    // transfer sequencing and request/response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pwrite <= 1'b0;
            paddr  <= '0;
            pwdata <= '0;
            rdata  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_SETUP;
                    pwrite <= start_write;
                    paddr  <= start_addr;
                    pwdata <= start_wdata;
                end
                ST_SETUP: state <= ST_ACCESS;
                ST_ACCESS: if (pready) begin
                    state <= ST_IDLE;
                    if (!pwrite) rdata <= prdata;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // bus phase outputs and completion events
    always_comb begin
        psel     = (state != ST_IDLE);
        penable  = (state == ST_ACCESS);
        busy     = psel;
        done     = penable && pready;
        err_done = done && pslverr;
    end

    AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel); // R6
    AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable)); // R6
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && !pready) |=> (penable && $stable(paddr) && $stable(pwrite))); // R9
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && pready) |=> !psel); // R9
endmodule

// File: rtl/jab_status_track.sv
// Sticky two-bit error status. Clear has top priority, then overlap,
// then slave error, which only marks a clean status.
module jab_status_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       overlap,
    input  logic       slv_err,
    output logic [1:0] status
);
    import jab_pkg::*;

    // update the sticky status from the three events
    always_ff @(posedge clk) begin
        if (!rst_n)                          status <= STAT_OK;
        else if (clr)                        status <= STAT_OK;
        else if (overlap)                    status <= STAT_OVERLAP;
        else if (slv_err && status == STAT_OK) status <= STAT_SLVERR;
    end

    AST_OVERLAP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_OVERLAP && !clr) |=> (status == STAT_OVERLAP)); // R11
endmodule

// File: rtl/jtag_apb_bridge.sv
// JTAG TAP client that runs APB transfers from access-word updates.
// Assumes the TAP holds act for one cycle per action and that dr_in
// is valid whenever act is update.
module jtag_apb_bridge #(
    parameter int          IR_W      = 5,
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] ID_VALUE  = 32'h0A35_C0DF,
    parameter int          IR_IDCODE = 1,
    parameter int          IR_CTRL   = 16,
    parameter int          IR_ACCESS = 17,
    localparam int         DR_W      = ADDR_W + DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IR_W-1:0]   ir,
    input  logic [1:0]        act,
    input  logic [DR_W-1:0]   dr_in,
    output logic [DR_W-1:0]   dr_out,
    output logic [DR_W-1:0]   dr_msb_mask,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    input  logic              pslverr
);
    import jab_pkg::*;

    jab_act_e          act_e;
    jab_sel_e          sel;
    logic              upd;
    logic              req;
    logic              start;
    logic              overlap;
    logic              clr;
    logic              busy;
    logic              err_done;
    logic [1:0]        status;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        op;

    // classify the TAP action into request, drop and clear events
    always_comb begin
        act_e   = jab_act_e'(act);
        op      = dr_in[1:0];
        upd     = (act_e == ACT_UPDATE);
        req     = upd && (sel == SEL_ACCESS) && (op == OP_READ || op == OP_WRITE);
        start   = req && !busy;
        overlap = req && busy;
        clr     = upd && (sel == SEL_CTRL) && (|dr_in[CTRL_CLR_HI:CTRL_CLR_LO]);
    end

    jab_ir_decode #(
        .IR_W(IR_W), .IR_IDCODE(IR_IDCODE), .IR_CTRL(IR_CTRL), .IR_ACCESS(IR_ACCESS)
    ) u_decode (
        .ir (ir),
        .sel(sel)
    );

    jab_apb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_write(op == OP_WRITE),
        .start_addr (dr_in[DR_W-1 -: ADDR_W]),
        .start_wdata(dr_in[2 +: DATA_W]),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .pready     (pready),
        .pslverr    (pslverr),
        .busy       (busy),
        .err_done   (err_done),
        .rdata      (rdata)
    );

    jab_status_track u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .overlap(overlap),
        .slv_err(err_done),
        .status (status)
    );

    jab_scan_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(32), .CTRL_W(32), .ID_VALUE(ID_VALUE)
    ) u_scan (
        .act        (act_e),
        .sel        (sel),
        .dr_in      (dr_in),
        .status     (status),
        .busy       (busy),
        .last_addr  (paddr),
        .rdata      (rdata),
        .dr_out     (dr_out),
        .dr_msb_mask(dr_msb_mask)
    );

    AST_START_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> (psel && !penable)); // R6
    AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req && busy) |=> (status == STAT_OVERLAP)); // R10
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == STAT_OK)); // R12
endmodule

// File: tb/jtag_apb_bridge_bench.sv
// Self-checking bench: directed corner cases plus seeded random accesses.
module jtag_apb_bridge_bench;
    localparam logic [31:0] IDV = 32'h0A35_C0DF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ir = 5'd0;
    logic [1:0]  act = 2'd0;
    logic [49:0] dr_in = '0;
    logic [49:0] dr_out, dr_msb_mask;
    logic        psel, penable, pwrite, pready = 1'b0, pslverr = 1'b0;
    logic [15:0] paddr;
    logic [31:0] pwdata, prdata;

    int checks = 0;
    int bad = 0;
    logic [15:0] last_m = '0;
    logic [31:0] rd_m = '0;
    logic [1:0]  st_m = 2'b00;

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_rd(input logic [15:0] a);
        return {a ^ 16'hA5C3, ~a};
    endfunction

    function automatic logic [49:0] exp_ctrl(input logic [1:0] s, input logic b);
        logic [49:0] v = '0;
        v[11:10] = s;
        v[12] = b;
        return v;
    endfunction

    assign prdata = exp_rd(paddr);

    jtag_apb_bridge u_jtag_apb_bridge (
        .clk(clk), .rst_n(rst_n), .ir(ir), .act(act), .dr_in(dr_in),
        .dr_out(dr_out), .dr_msb_mask(dr_msb_mask), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic cap(input logic [4:0] code, input logic [49:0] e, input int top, input string tag);
        @(negedge clk);
        ir = code; act = 2'd1;
        #1;
        chk(dr_out == e, tag, 64'(dr_out), 64'(e));
        chk(dr_msb_mask == (50'd1 << top), {tag, " mask"}, 64'(dr_msb_mask), 64'(50'd1 << top));
        act = 2'd0;
    endtask

    task automatic do_access(input logic [15:0] a, input logic [31:0] d, input logic [1:0] op,
                             input int waits, input bit err);
        @(negedge clk);
        ir = 5'h11; dr_in = {a, d, op}; act = 2'd3;
        @(negedge clk);
        act = 2'd0;
        if (op == 2'd1 || op == 2'd2) begin
            chk(psel && !penable, "R6 setup phase", {62'd0, psel, penable}, 64'h2);
            chk(paddr == a && pwrite == (op == 2'd2), "R6 R7 addr/dir",
                {47'd0, pwrite, paddr}, {47'd0, op == 2'd2, a});
            if (op == 2'd2) chk(pwdata == d, "R7 wdata", 64'(pwdata), 64'(d));
            last_m = a;
            @(negedge clk);
            for (int i = 0; i < waits; i++) begin
                chk(psel && penable && paddr == a, "R9 hold", {46'd0, psel, penable, paddr}, {46'd0, 2'b11, a});
                @(negedge clk);
            end
            chk(psel && penable, "R6 access phase", {62'd0, psel, penable}, 64'h3);
            pready = 1'b1; pslverr = err;
            @(negedge clk);
            pready = 1'b0; pslverr = 1'b0;
            chk(!psel, "R9 idle after ready", 64'(psel), 64'd0);
            if (op == 2'd1) rd_m = exp_rd(a);
            if (err && st_m == 2'b00) st_m = 2'b01;
        end else begin
            chk(!psel, "R8 no transfer", 64'(psel), 64'd0);
        end
        cap(5'h11, {last_m, rd_m, st_m}, 49, "R4 R11 access capture");
    endtask

    task automatic ctrl_upd(input logic [49:0] v);
        @(negedge clk);
        ir = 5'h10; dr_in = v; act = 2'd3;
        @(negedge clk);
        act = 2'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(!psel && !penable, "R13 reset bus", {62'd0, psel, penable}, 64'd0);
        cap(5'h11, 50'd0, 49, "R13 reset access");
        cap(5'h10, 50'd0, 31, "R13 reset ctrl");
        @(negedge clk); rst_n = 1'b1;

        // R1 identification
        cap(5'h01, {18'd0, IDV}, 31, "R1 idcode");
        // R2 bypass on several codes
        cap(5'h00, 50'd0, 0, "R2 bypass 0");
        cap(5'h1F, 50'd0, 0, "R2 bypass 1f");
        cap(5'h12, 50'd0, 0, "R2 bypass 12");
        // R5 shift/idle/update pass-through
        for (int k = 0; k < 4; k++) begin
            logic [49:0] v = {$urandom, $urandom};
            @(negedge clk);
            ir = 5'($urandom); dr_in = v; act = 2'd2; #1;
            chk(dr_out == (v >> 1), "R5 shift", 64'(dr_out), 64'(v >> 1));
            act = 2'd0; #1;
            chk(dr_out == v, "R5 idle", 64'(dr_out), 64'(v));
        end
        // R8 update of bypass/idcode starts nothing
        @(negedge clk); ir = 5'h00; dr_in = {16'h1234, 32'h0, 2'd1}; act = 2'd3; #1;
        chk(dr_out == dr_in, "R5 update passthrough", 64'(dr_out), 64'(dr_in));
        @(negedge clk); ir = 5'h01; act = 2'd3;
        @(negedge clk); act = 2'd0;
        chk(!psel, "R8 non-access update", 64'(psel), 64'd0);

        // directed transfers
        do_access(16'hBEEF, 32'h0, 2'd1, 0, 1'b0);
        do_access(16'h0102, 32'hDEAD_BEEF, 2'd2, 3, 1'b0);
        do_access(16'h7777, 32'h1, 2'd0, 0, 1'b0);
        do_access(16'h8888, 32'h2, 2'd3, 0, 1'b0);
        do_access(16'h4444, 32'h0, 2'd1, 2, 1'b1); // R11 error
        ctrl_upd(50'd1 << 17); st_m = 2'b00;
        cap(5'h10, exp_ctrl(2'b00, 1'b0), 31, "R12 clear bit17");

        // R10 overlap during wait states
        @(negedge clk); ir = 5'h11; dr_in = {16'hAAAA, 32'h5555_0000, 2'd2}; act = 2'd3;
        @(negedge clk); act = 2'd0;
        @(negedge clk); ir = 5'h11; dr_in = {16'h0BAD, 32'h0, 2'd1}; act = 2'd3;
        @(negedge clk); act = 2'd0;
        chk(psel && penable && paddr == 16'hAAAA, "R10 dropped request", 64'(paddr), 64'hAAAA);
        cap(5'h10, exp_ctrl(2'b11, 1'b1), 31, "R10 R3 overlap busy");
        @(negedge clk); pready = 1'b1;
        @(negedge clk); pready = 1'b0;
        last_m = 16'hAAAA; st_m = 2'b11;
        cap(5'h10, exp_ctrl(2'b11, 1'b0), 31, "R3 not busy");
        ctrl_upd(50'h3); // bits [17:2] zero except bit 2? no: 3 = bits 0,1
        cap(5'h10, exp_ctrl(2'b11, 1'b0), 31, "R12 zero field no effect");
        ctrl_upd(50'd1 << 2); st_m = 2'b00;
        cap(5'h10, exp_ctrl(2'b00, 1'b0), 31, "R12 clear bit2");

        // R10 completion and new request on the same edge
        @(negedge clk); ir = 5'h11; dr_in = {16'h3210, 32'h0, 2'd1}; act = 2'd3;
        @(negedge clk); act = 2'd0;
        @(negedge clk); pready = 1'b1; dr_in = {16'h9999, 32'h1, 2'd2}; act = 2'd3;
        @(negedge clk); pready = 1'b0; act = 2'd0;
        chk(!psel, "R10 request at completion dropped", 64'(psel), 64'd0);
        last_m = 16'h3210; rd_m = exp_rd(16'h3210); st_m = 2'b11;
        cap(5'h11, {last_m, rd_m, st_m}, 49, "R10 R9 completion collision");
        ctrl_upd(50'd1 << 9); st_m = 2'b00;

        // R12 clear wins over slave error on same edge
        @(negedge clk); ir = 5'h11; dr_in = {16'h5A5A, 32'hF0F0, 2'd2}; act = 2'd3;
        @(negedge clk); act = 2'd0;
        @(negedge clk); pready = 1'b1; pslverr = 1'b1; ir = 5'h10; dr_in = 50'd1 << 5; act = 2'd3;
        @(negedge clk); pready = 1'b0; pslverr = 1'b0; act = 2'd0;
        last_m = 16'h5A5A;
        cap(5'h10, exp_ctrl(2'b00, 1'b0), 31, "R12 clear beats error");

        // random accesses
        for (int n = 0; n < 40; n++) begin
            do_access(16'($urandom), $urandom, 2'($urandom), int'($urandom % 4), ($urandom % 4) == 0);
            if (n % 8 == 7) begin
                ctrl_upd(50'd1 << (2 + ($urandom % 16)));
                st_m = 2'b00;
                cap(5'h10, exp_ctrl(2'b00, 1'b0), 31, "R12 random clear");
            end
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule